// File: doc/BRIEF.md
# Tree-Structured Fixed-Priority Grant Selector

This block picks one winner among N request lines, always favouring the highest-numbered request that is set, and raises the matching grant line. It is purely combinational. Inside, it is built only from identical two-input selector nodes arranged as a balanced binary tree.

Each node passes a pending-request flag up to its parent. The parent's grant bits come back down as the enables of its two children. The external enable feeds the root node, so a low enable blocks the whole tree. The root's pending-request flag is brought out as a port, so a copy of this selector can itself serve as a subtree under another node.

An 8-input selector is made from two 4-input subtrees and one root node. A 4-input selector is made from two leaf nodes and one root node. No logic sits between the nodes beyond the wires that join them.

Top module: `prio_tree_sel`

## Requirements
- R1: With enable high and at least one request set, exactly the grant bit at the index of the highest-numbered set request is high.
- R2: At most one grant bit is high at any time.
- R3: With enable low, all grant bits are low, whatever the requests.
- R4: With enable high and every request set, only grant bit N_REQ-1 is high (4'b1000 for four inputs, 8'b1000_0000 for eight).
- R5: The pending-request output is high exactly when any request bit is set, regardless of enable.
- R6: A grant bit is never high unless its own request bit is high.
- R7: With no request set, all grant bits are low and the pending-request output is low.
- R8: N_REQ may be any power of two of at least 2. Both the 4-input and the 8-input builds meet R1 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Enable for the whole tree; low forces all grants low |
| req_i | input | N_REQ | Request lines; bit N_REQ-1 has the highest priority |
| gnt_o | output | N_REQ | One-hot-or-zero grant lines |
| req_up_o | output | 1 | High when any request is pending, independent of enable |

## Verification
On every input change, the assertions check several properties between the tree's output and its inputs:
- the grant is one-hot or zero;
- no grant appears on a line that is not requesting;
- a low enable or an empty request vector yields no grant;
- any grant implies the pending flag is set.

Those checks cannot tell which requester won. That the winner is the highest-numbered requester is shown only by the bench. It sweeps every request pattern with enable high and low, on both the 8-input and the 4-input builds, and compares the result against an arithmetic search for the top set bit.

// File: rtl/prio_tree_pkg.sv
package prio_tree_pkg;
  // true when n is a power of two and at least 2
  function automatic bit legal_width(int unsigned n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/prio_node.sv
module prio_node (
  input  logic       en_i,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o,
  output logic       req_up_o
);
  assign gnt_o[1]  = en_i & req_i[1];
  assign gnt_o[0]  = en_i & req_i[0] & ~req_i[1];
  assign req_up_o  = req_i[1] | req_i[0];
endmodule

// File: rtl/prio_subtree.sv
module prio_subtree #(
  parameter int unsigned N_REQ = 4
) (
  input  logic             en_i,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic             req_up_o
);
  localparam int unsigned HALF = N_REQ / 2;

  generate
    if (N_REQ == 2) begin : g_leaf
      prio_node u_node (
        .en_i    (en_i),
        .req_i   (req_i),
        .gnt_o   (gnt_o),
        .req_up_o(req_up_o)
      );
    end else begin : g_split
      logic [1:0] child_up;
      logic [1:0] child_en;

      prio_subtree #(.N_REQ(HALF)) u_lo (
        .en_i    (child_en[0]),
        .req_i   (req_i[HALF-1:0]),
        .gnt_o   (gnt_o[HALF-1:0]),
        .req_up_o(child_up[0])
      );
      prio_subtree #(.N_REQ(HALF)) u_hi (
        .en_i    (child_en[1]),
        .req_i   (req_i[N_REQ-1:HALF]),
        .gnt_o   (gnt_o[N_REQ-1:HALF]),
        .req_up_o(child_up[1])
      );
      // root grant bits become the children's enables
      prio_node u_root (
        .en_i    (en_i),
        .req_i   (child_up),
        .gnt_o   (child_en),
        .req_up_o(req_up_o)
      );
    end
  endgenerate
endmodule

// File: rtl/prio_tree_sel.sv
module prio_tree_sel
  import prio_tree_pkg::*;
#(
  parameter int unsigned N_REQ = 8
) (
  input  logic             en_i,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic             req_up_o
);
  initial begin
    if (!legal_width(N_REQ)) $error("N_REQ must be a power of two >= 2");
  end

  prio_subtree #(.N_REQ(N_REQ)) u_tree (
    .en_i    (en_i),
    .req_i   (req_i),
    .gnt_o   (gnt_o),
    .req_up_o(req_up_o)
  );

  always_comb begin
    a_r2_onehot_gnt: assert ($onehot0(gnt_o));
    a_r3_en_low_blocks: assert (en_i || gnt_o == '0);
    a_r6_gnt_within_req: assert ((gnt_o & ~req_i) == '0);
    a_r7_no_req_no_gnt: assert (req_i != '0 || gnt_o == '0);
    a_r1_some_winner: assert (!(en_i && req_i != '0) || gnt_o != '0);
    a_r5_gnt_implies_up: assert (gnt_o == '0 || req_up_o);
  end
endmodule

// File: tb/prio_tree_sel_bench.sv
module prio_tree_sel_bench;
  localparam int unsigned NA = 8;
  localparam int unsigned NB = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          en_a, en_b;
  logic [NA-1:0] req_a, gnt_a;
  logic [NB-1:0] req_b, gnt_b;
  logic          up_a, up_b;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  prio_tree_sel #(.N_REQ(NA)) u_prio_tree_sel (
    .en_i(en_a), .req_i(req_a), .gnt_o(gnt_a), .req_up_o(up_a));
  prio_tree_sel #(.N_REQ(NB)) u_prio_tree_sel_4 (
    .en_i(en_b), .req_i(req_b), .gnt_o(gnt_b), .req_up_o(up_b));

  function automatic logic [NA-1:0] top_bit(logic [NA-1:0] r, int unsigned w);
    logic [NA-1:0] g = '0;
    for (int i = 0; i < int'(w); i++) if (r[i]) g = '0 | (NA'(1) << i);
    return g;
  endfunction

  task automatic chk(string tag, logic [NA-1:0] act, logic [NA-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic sweep8(logic en);
    for (int p = 0; p < (1 << NA); p++) begin
      logic [NA-1:0] e;
      en_a = en; req_a = NA'(p);
      @(negedge clk);
      e = en ? top_bit(NA'(p), NA) : '0;
      // R1 highest wins, R3 enable gate, R6/R7 implied by reference
      chk(en ? "R1 gnt8" : "R3 gnt8", gnt_a, e);
      // R5 pending flag independent of enable
      chk("R5 up8", NA'(up_a), NA'(p != 0));
      if ($countones(gnt_a) > 1) chk("R2 onehot8", gnt_a, e);
    end
  endtask

  task automatic sweep4(logic en);
    for (int p = 0; p < (1 << NB); p++) begin
      logic [NA-1:0] e;
      en_b = en; req_b = NB'(p);
      @(negedge clk);
      e = en ? top_bit(NA'(p), NB) : '0;
      chk("R8 gnt4", NA'(gnt_b), e);
      chk("R8 up4", NA'(up_b), NA'(p != 0));
    end
  endtask

  initial begin
    en_a = 1'b0; req_a = '0; en_b = 1'b0; req_b = '0;
    @(negedge clk);
    // R7 idle state
    chk("R7 idle gnt8", gnt_a, '0);
    chk("R7 idle up8", NA'(up_a), '0);
    // R4 all requests set
    en_a = 1'b1; req_a = '1; en_b = 1'b1; req_b = '1;
    @(negedge clk);
    chk("R4 all8", gnt_a, 8'b1000_0000);
    chk("R4 all4", NA'(gnt_b), NA'(4'b1000));
    // R3 all set, enable low
    en_a = 1'b0; en_b = 1'b0;
    @(negedge clk);
    chk("R3 all8 en0", gnt_a, '0);
    chk("R3 all4 en0", NA'(gnt_b), '0);
    chk("R5 up with en0", NA'(up_a), NA'(1));
    // R6 lowest line alone
    en_a = 1'b1; req_a = 8'b0000_0001;
    @(negedge clk);
    chk("R6 lsb only", gnt_a, 8'b0000_0001);
    sweep8(1'b1);
    sweep8(1'b0);
    sweep4(1'b1);
    sweep4(1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule